// File: doc/BRIEF.md
# Assertion Result Trace Compactor

This block sits between a bank of hardware assertion checkers and a debug trace port whose width is smaller than the number of checkers. It receives `K` fire signals every cycle. It groups them into `S` equal sets of `L = ceil(K/S)` bits, with the last set padded with zeros. Each cycle it reports exactly one set as a registered trace word. The word holds the set's index and every fire flag of that set, so several violations inside one set remain individually visible.

When violations fall in more than one set, the lowest-numbered set wins. The fire bits of the losing sets are held as pending. They are merged with any new firings and reported on later cycles. A sticky overflow flag records that an assertion fired again while its previous firing was still waiting. After that, the trace no longer separates those repeated events. The flag is cleared only by reset.

With the defaults, `K=10` and `S=4`. This gives `L=3`, a 2-bit index, and an 8-bit word `M`.

Top module: `assertion_trace_compactor`

## Requirements
- R1: While `rst_n` is low, `trace_valid`, `trace_word` and `overflow` are all zero, and the pending store is emptied.
- R2: The trace word carries the set index in bits `[IW-1:0]` (IW = ceil(log2 S), minimum 1) and the set's flags in bits `[IW+L-1:IW]`. Flag j is assertion `index*L + j`. All bits above `IW+L` are zero.
- R3: The set chosen is the lowest-numbered set that has a new or pending violation. The result appears on the outputs after the next rising clock edge.
- R4: All violating bits of the chosen set appear together in one word.
- R5: Violations in sets that are not chosen are kept and emitted on later cycles in the same priority order. None is lost.
- R6: A pending bit and a new firing in the same set are ORed into the same word.
- R7: `trace_valid` is high exactly in cycles that emit a violation. When it is low, `trace_word` is zero. Any firing produces a valid word on the following cycle.
- R8: `overflow` rises when a fire input is high while the same assertion is already pending. It then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fire | input | K | Assertion fire signals, one per checker |
| trace_valid | output | 1 | Trace word carries a violation |
| trace_word | output | M | Packed set index and set-local flags |
| overflow | output | 1 | Sticky: a pending assertion fired again |

## Verification
A pending store that drops a bit shows up as a set index that never appears at the port. That absence is visible within S cycles of a burst that hits every set. A pending bit that is never cleared keeps `trace_valid` high on idle cycles, starting one cycle after its set is emitted. A wrong priority or a wrong flag placement corrupts the very next word after the triggering fire pattern. A missing overflow shows up as `overflow` still low one cycle after a repeat firing.

// File: rtl/assertion_trace_compactor.sv
module assertion_trace_compactor #(
  parameter int K = 10,
  parameter int S = 4,
  parameter int M = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [K-1:0] fire,
  output logic         trace_valid,
  output logic [M-1:0] trace_word,
  output logic         overflow
);
  localparam int L  = (K + S - 1) / S;
  localparam int IW = (S > 1) ? $clog2(S) : 1;
  localparam int W  = S * L;

  logic [W-1:0]  fire_ext, pend_q, merged, clr_mask;
  logic [IW-1:0] sel;
  logic [L-1:0]  sel_bits;
  logic          any;
  logic [M-1:0]  word_d;

  assign fire_ext = W'(fire);
  assign merged   = pend_q | fire_ext;
  assign any      = |merged;

  always_comb begin
    sel = '0;
    for (int s = S - 1; s >= 0; s--)
      if (|merged[s*L +: L]) sel = IW'(s);
  end

  assign sel_bits = merged[sel*L +: L];

  always_comb begin
    clr_mask = '0;
    clr_mask[sel*L +: L] = {L{any}};
  end

  always_comb begin
    word_d = '0;
    if (any) begin
      word_d[IW-1:0]    = sel;
      word_d[IW+L-1:IW] = sel_bits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= '0;
      trace_valid <= 1'b0;
      trace_word  <= '0;
      overflow    <= 1'b0;
    end else begin
      pend_q      <= merged & ~clr_mask;
      trace_valid <= any;
      trace_word  <= word_d;
      if (|(fire_ext & pend_q)) overflow <= 1'b1;
    end
  end

  initial begin
    if (M < IW + L) $error("trace word too narrow for index plus set flags");
  end
endmodule

// File: rtl/atc_checker.sv
module atc_checker #(
  parameter int K = 10,
  parameter int S = 4,
  parameter int M = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [K-1:0] fire,
  input logic         trace_valid,
  input logic [M-1:0] trace_word,
  input logic         overflow
);
  localparam int L  = (K + S - 1) / S;
  localparam int IW = (S > 1) ? $clog2(S) : 1;

  // R7
  idle_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trace_valid |-> trace_word == '0);

  // R7
  fire_yields_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|fire) |=> trace_valid);

  // R2
  upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_word >> (IW + L)) == '0);

  // R2
  index_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trace_valid |-> int'(trace_word[IW-1:0]) < S);

  // R4
  flags_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trace_valid |-> |trace_word[IW+L-1:IW]);

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

bind assertion_trace_compactor atc_checker #(.K(K), .S(S), .M(M)) chk (.*);

// File: tb/assertion_trace_compactor_test.sv
module assertion_trace_compactor_test;
  localparam int CLK_T = 10;
  localparam int K = 10;
  localparam int M = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [K-1:0] fire = '0;
  logic         trace_valid;
  logic [M-1:0] trace_word;
  logic         overflow;
  int checks = 0;
  int fails = 0;

  always #(CLK_T/2) clk = ~clk;

  assertion_trace_compactor #(.K(K), .S(4), .M(M)) uut (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .trace_valid(trace_valid), .trace_word(trace_word), .overflow(overflow)
  );

  // {fire[9:0], valid, overflow, word[7:0]}; word = {000, flags[2:0], idx[1:0]}
  localparam logic [19:0] VEC [7] = '{
    {10'h000, 1'b0, 1'b0, 8'h00},
    {10'h006, 1'b1, 1'b0, 8'h18},
    {10'h210, 1'b1, 1'b0, 8'h09},
    {10'h000, 1'b1, 1'b0, 8'h07},
    {10'h1C1, 1'b1, 1'b0, 8'h04},
    {10'h040, 1'b1, 1'b1, 8'h1E},
    {10'h000, 1'b0, 1'b1, 8'h00}
  };

  task automatic check(string req, logic v, logic o, logic [M-1:0] w);
    checks++;
    if (trace_valid !== v || overflow !== o || trace_word !== w) begin
      fails++;
      $display("FAIL %s: got valid=%b ovf=%b word=%h, expected valid=%b ovf=%b word=%h",
               req, trace_valid, overflow, trace_word, v, o, w);
    end
  endtask

  task automatic step(logic [K-1:0] f, string req, logic v, logic o, logic [M-1:0] w);
    fire = f;
    @(posedge clk);
    #(CLK_T/4);
    check(req, v, o, w);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fire  = '1;
    #(CLK_T/4);
    check("R1 reset", 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    fire  = '0;
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_T * 100000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // table: R2 layout, R3 priority, R4 multi-bit, R5 pending, R7 valid, R8 overflow
    for (int i = 0; i < 7; i++)
      step(VEC[i][19:10], "R2/R3/R4/R5/R7/R8 table", VEC[i][9], VEC[i][8], VEC[i][7:0]);

    // R1: reset clears sticky overflow
    do_reset();
    step('0, "R1 after reset", 1'b0, 1'b0, 8'h00);

    // R3 R5: burst on every set drains in ascending order
    step(10'h3FF, "R3 burst set0", 1'b1, 1'b0, 8'h1C);
    step('0, "R5 burst set1", 1'b1, 1'b0, 8'h1D);
    step('0, "R5 burst set2", 1'b1, 1'b0, 8'h1E);
    step('0, "R5 burst set3", 1'b1, 1'b0, 8'h07);
    step('0, "R7 drained idle", 1'b0, 1'b0, 8'h00);

    // R6: pending bit3 merges with new bit5 in set1
    step(10'h009, "R6 set0 first", 1'b1, 1'b0, 8'h04);
    step(10'h020, "R6 merged set1", 1'b1, 1'b0, 8'h15);
    step('0, "R7 idle after merge", 1'b0, 1'b0, 8'h00);

    // R8: repeat firing of a pending bit in a low set blocked by set0
    step(10'h081, "R8 prime", 1'b1, 1'b0, 8'h04);
    step(10'h080, "R8 repeat", 1'b1, 1'b1, 8'h0A);
    step('0, "R8 sticky", 1'b0, 1'b1, 8'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule